// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs from the oscillator clock and makes a slower count clock by dividing that clock by a fixed factor. It then steps through four phases in a fixed order: auto-zero, signal integrate, de-integrate and zero-integrate. For each phase it drives one switch enable to the analog front end. The de-integrate phase has two enables, and the sign seen at the end of signal integrate picks which one is used.

The block measures de-integrate time with a decade counter. The counter stops on the first count tick at which the comparator reports that the integrator has returned to zero. At the end of de-integrate, the count, the sign and an overrange flag are copied into output registers together in one clock. They hold there until the next conversion.

Every conversion takes the same number of oscillator clocks. Auto-zero absorbs the time left over by a short de-integrate and by the zero-integrate phase. Zero-integrate normally ends on the comparator, within a minimum and a maximum length. After a de-integrate that hit its limit, zero-integrate runs for a longer fixed length so that the next reading is already correct.

Top module: `dual_slope_sequencer`

## Requirements
- R1: Exactly one of swAutoZero, swIntegrate, swDeRefUp, swDeRefDown, swZeroInt is high in every clock after reset. The phases follow the order auto-zero, signal integrate, de-integrate, zero-integrate, and then auto-zero again.
- R2: Signal integrate lasts INT_COUNTS*PRESCALE oscillator clocks.
- R3: In de-integrate, the comparator is sampled once per count tick, which is every PRESCALE-th clock. The first tick in de-integrate is the PRESCALE-th clock of the phase. De-integrate ends on the first tick with cmpCross high. The reading N is the number of earlier ticks in the phase, so the phase lasts PRESCALE*(N+1) clocks.
- R4: If cmpCross is still low on tick DE_MAX-1, de-integrate ends there and lasts PRESCALE*DE_MAX clocks. The latched overrange flag is then 1 and all latched digits are 0.
- R5: polNeg is sampled on the last clock of signal integrate. If polNeg was 1, swDeRefUp is the de-integrate enable; if it was 0, swDeRefDown is. The sampled value is latched to rdNegative. Changes of polNeg during de-integrate have no effect.
- R6: After a normal de-integrate, zero-integrate lasts min(ZI_MAX, max(ZI_MIN, k)) clocks. Here k is the first clock of the phase (counted from 1) on which cmpCross is high.
- R7: After an overrange de-integrate, zero-integrate lasts exactly ZI_HEAVY clocks, whatever cmpCross does.
- R8: From the start of one signal integrate to the start of the next is always CYCLE_COUNTS*PRESCALE clocks. Auto-zero takes the remainder.
- R9: The reading is BCD: rdUnits, rdTens and rdHundreds are 4 bits each with values 0 to 9, and rdThousand is 1 bit. The output registers change only on the clock edge that ends de-integrate. They hold their value at all other times.
- R10: Synchronous reset puts the block in auto-zero with all output registers at 0. The first auto-zero after reset lasts (CYCLE_COUNTS-INT_COUNTS-DE_MAX)*PRESCALE clocks.
- R11: cmpCross and polNeg have no effect on the length of auto-zero or signal integrate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpCross | input | 1 | Comparator: integrator has returned to zero |
| polNeg | input | 1 | Comparator polarity: integrated input is negative |
| swAutoZero | output | 1 | Auto-zero switch enable |
| swIntegrate | output | 1 | Signal integrate switch enable |
| swDeRefUp | output | 1 | De-integrate enable, reference polarity for negative inputs |
| swDeRefDown | output | 1 | De-integrate enable, reference polarity for positive inputs |
| swZeroInt | output | 1 | Zero-integrate switch enable |
| rdUnits | output | 4 | Latched units digit, BCD |
| rdTens | output | 4 | Latched tens digit, BCD |
| rdHundreds | output | 4 | Latched hundreds digit, BCD |
| rdThousand | output | 1 | Latched thousands digit |
| rdNegative | output | 1 | Latched sign, 1 for a negative input |
| rdOverrange | output | 1 | Latched overrange flag |

## Verification
The bench builds the block with PRESCALE=4, INT_COUNTS=100, DE_MAX=200, CYCLE_COUNTS=400, ZI_MIN=11, ZI_MAX=140 and ZI_HEAVY=300. This gives a conversion of 1600 clocks, so about fifty conversions fit in the run. A reading of up to 199 reaches the units-to-tens and tens-to-hundreds carries as well as the full-scale count. A value above 199 gives an overrange, followed by the extended zero-integrate and a recovery in the next conversion. The shortest auto-zero, which follows an overrange, is then 100 clocks. The thousands digit and the default timing scale are not reached by this configuration.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2,
    PH_ZI  = 2'd3
  } phase_e;

  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic sampleSign;
    logic latchOut;
    logic ovrFlag;
  } strobes_t;

  // {thousand, hundreds, tens, units}
  function automatic logic [12:0] toBcd(input int value);
    logic [12:0] r;
    r[3:0]   = 4'(value % 10);
    r[7:4]   = 4'((value / 10) % 10);
    r[11:8]  = 4'((value / 100) % 10);
    r[12]    = 1'((value / 1000) % 2);
    return r;
  endfunction

endpackage

// File: rtl/dss_bcd_digit.sv
module dss_bcd_digit (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       carryIn,
  output logic [3:0] digit,
  output logic       carryOut
);

  assign carryOut = carryIn && (digit == 4'd9);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      digit <= 4'd0;
    end else if (carryIn) begin
      digit <= (digit == 4'd9) ? 4'd0 : digit + 4'd1;
    end
  end

endmodule

// File: rtl/dss_datapath.sv
module dss_datapath
  import dss_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int DE_MAX   = 2000
) (
  input  logic        clk,
  input  logic        rst,
  input  strobes_t    strobe,
  input  logic        polNeg,
  output logic        tick,
  output logic        atMax,
  output logic        signNeg,
  output logic [12:0] rdBcd,
  output logic        rdNeg,
  output logic        rdOvr
);

  localparam int PRE_W = $clog2(PRESCALE);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [12:0] MAX_BCD = toBcd(DE_MAX - 1);

  logic [PRE_W-1:0] preCount;
  logic [2:0][3:0]  digits;
  logic [3:0]       carry;
  logic             thousandQ;
  logic [12:0]      countBcd;

  // count-clock prescaler
  always_ff @(posedge clk) begin
    if (rst) preCount <= '0;
    else if (preCount == PRE_LAST) preCount <= '0;
    else preCount <= preCount + 1'b1;
  end
  assign tick = (preCount == PRE_LAST);

  // decade counter chain
  assign carry[0] = strobe.incCount;
  for (genvar i = 0; i < 3; i++) begin : g_digit
    dss_bcd_digit u_digit (
      .clk      (clk),
      .rst      (rst),
      .clr      (strobe.clrCount),
      .carryIn  (carry[i]),
      .digit    (digits[i]),
      .carryOut (carry[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrCount) thousandQ <= 1'b0;
    else if (carry[3]) thousandQ <= 1'b1;
  end

  assign countBcd = {thousandQ, digits[2], digits[1], digits[0]};
  assign atMax    = (countBcd == MAX_BCD);

  always_ff @(posedge clk) begin
    if (rst) signNeg <= 1'b0;
    else if (strobe.sampleSign) signNeg <= polNeg;
  end

  // output latch
  always_ff @(posedge clk) begin
    if (rst) begin
      rdBcd <= '0;
      rdNeg <= 1'b0;
      rdOvr <= 1'b0;
    end else if (strobe.latchOut) begin
      rdBcd <= strobe.ovrFlag ? '0 : countBcd;
      rdNeg <= signNeg;
      rdOvr <= strobe.ovrFlag;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.latchOut |=> $stable({rdBcd, rdNeg, rdOvr}));

  p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
    (digits[0] <= 4'd9) && (digits[1] <= 4'd9) && (digits[2] <= 4'd9));

  p_ovr_blank_r4: assert property (@(posedge clk) disable iff (rst)
    rdOvr |-> (rdBcd == 13'd0));

endmodule

// File: rtl/dss_control.sv
module dss_control
  import dss_pkg::*;
#(
  parameter int PRESCALE     = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DE_MAX       = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int ZI_MIN       = 11,
  parameter int ZI_MAX       = 140,
  parameter int ZI_HEAVY     = 740
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cmpCross,
  input  logic     tick,
  input  logic     atMax,
  output strobes_t strobe,
  output phase_e   phase
);

  localparam int INT_OSC    = INT_COUNTS * PRESCALE;
  localparam int CYCLE_OSC  = CYCLE_COUNTS * PRESCALE;
  localparam int AZ_MIN_OSC = (CYCLE_COUNTS - INT_COUNTS - DE_MAX) * PRESCALE;
  localparam int POS_W      = $clog2(CYCLE_OSC);
  localparam int ZI_TOP     = (ZI_HEAVY > ZI_MAX) ? ZI_HEAVY : ZI_MAX;
  localparam int ZI_W       = $clog2(ZI_TOP + 1);

  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(CYCLE_OSC - 1);
  localparam logic [POS_W-1:0] POS_INT   = POS_W'(INT_OSC - 1);
  localparam logic [POS_W-1:0] POS_BOOT  = POS_W'(CYCLE_OSC - AZ_MIN_OSC);
  localparam logic [ZI_W-1:0]  ZI_LO     = ZI_W'(ZI_MIN - 1);
  localparam logic [ZI_W-1:0]  ZI_HI     = ZI_W'(ZI_MAX - 1);
  localparam logic [ZI_W-1:0]  ZI_LONG   = ZI_W'(ZI_HEAVY - 1);

  phase_e           phaseNext;
  logic [POS_W-1:0] cycPos;
  logic [ZI_W-1:0]  ziCount;
  logic             heavy;
  logic             ziDone;

  assign ziDone = heavy ? (ziCount == ZI_LONG)
                        : ((ziCount == ZI_HI) || ((ziCount >= ZI_LO) && cmpCross));

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      PH_AZ: begin
        if (cycPos == POS_LAST) phaseNext = PH_INT;
      end
      PH_INT: begin
        if (cycPos == POS_INT) begin
          phaseNext         = PH_DE;
          strobe.sampleSign = 1'b1;
          strobe.clrCount   = 1'b1;
        end
      end
      PH_DE: begin
        if (tick) begin
          if (cmpCross) begin
            strobe.latchOut = 1'b1;
            phaseNext       = PH_ZI;
          end else if (atMax) begin
            strobe.latchOut = 1'b1;
            strobe.ovrFlag  = 1'b1;
            phaseNext       = PH_ZI;
          end else begin
            strobe.incCount = 1'b1;
          end
        end
      end
      PH_ZI: begin
        if (ziDone) phaseNext = PH_AZ;
      end
      default: phaseNext = PH_AZ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_AZ;
      cycPos  <= POS_BOOT;
      ziCount <= '0;
      heavy   <= 1'b0;
    end else begin
      phase   <= phaseNext;
      cycPos  <= (cycPos == POS_LAST) ? '0 : cycPos + 1'b1;
      ziCount <= (phase == PH_ZI) ? ziCount + 1'b1 : '0;
      if (strobe.latchOut) heavy <= strobe.ovrFlag;
    end
  end

  p_int_exit_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INT && phaseNext == PH_DE) |-> tick);

  p_de_exit_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DE && phaseNext != PH_DE) |-> tick);

  p_order_r1: assert property (@(posedge clk) disable iff (rst)
    (phase != phaseNext) |-> (phaseNext == phase_e'(phase + 2'd1)));

endmodule

// File: rtl/dual_slope_sequencer.sv
module dual_slope_sequencer
  import dss_pkg::*;
#(
  parameter int PRESCALE     = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DE_MAX       = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int ZI_MIN       = 11,
  parameter int ZI_MAX       = 140,
  parameter int ZI_HEAVY     = 740
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmpCross,
  input  logic       polNeg,
  output logic       swAutoZero,
  output logic       swIntegrate,
  output logic       swDeRefUp,
  output logic       swDeRefDown,
  output logic       swZeroInt,
  output logic [3:0] rdUnits,
  output logic [3:0] rdTens,
  output logic [3:0] rdHundreds,
  output logic       rdThousand,
  output logic       rdNegative,
  output logic       rdOverrange
);

  localparam int CYCLE_OSC = CYCLE_COUNTS * PRESCALE;
  localparam int GAP_W     = $clog2(CYCLE_OSC + 1) + 1;

  strobes_t    strobe;
  phase_e      phase;
  logic        tick;
  logic        atMax;
  logic        signNeg;
  logic [12:0] rdBcd;

  dss_control #(
    .PRESCALE(PRESCALE), .INT_COUNTS(INT_COUNTS), .DE_MAX(DE_MAX),
    .CYCLE_COUNTS(CYCLE_COUNTS), .ZI_MIN(ZI_MIN), .ZI_MAX(ZI_MAX),
    .ZI_HEAVY(ZI_HEAVY)
  ) u_control (
    .clk(clk), .rst(rst), .cmpCross(cmpCross), .tick(tick),
    .atMax(atMax), .strobe(strobe), .phase(phase)
  );

  dss_datapath #(
    .PRESCALE(PRESCALE), .DE_MAX(DE_MAX)
  ) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .polNeg(polNeg),
    .tick(tick), .atMax(atMax), .signNeg(signNeg),
    .rdBcd(rdBcd), .rdNeg(rdNegative), .rdOvr(rdOverrange)
  );

  assign swAutoZero  = (phase == PH_AZ);
  assign swIntegrate = (phase == PH_INT);
  assign swDeRefUp   = (phase == PH_DE) && signNeg;
  assign swDeRefDown = (phase == PH_DE) && !signNeg;
  assign swZeroInt   = (phase == PH_ZI);

  assign rdUnits    = rdBcd[3:0];
  assign rdTens     = rdBcd[7:4];
  assign rdHundreds = rdBcd[11:8];
  assign rdThousand = rdBcd[12];

  // conversion period monitor
  logic             intPrev;
  logic             gapSeen;
  logic [GAP_W-1:0] gapCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      intPrev  <= 1'b0;
      gapSeen  <= 1'b0;
      gapCount <= '0;
    end else begin
      intPrev <= swIntegrate;
      if (swIntegrate && !intPrev) begin
        gapSeen  <= 1'b1;
        gapCount <= GAP_W'(1);
      end else if (gapCount != '1) begin
        gapCount <= gapCount + 1'b1;
      end
    end
  end

  p_one_phase_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot({swAutoZero, swIntegrate, swDeRefUp, swDeRefDown, swZeroInt}));

  p_cycle_len_r8: assert property (@(posedge clk) disable iff (rst)
    (swIntegrate && !intPrev && gapSeen) |-> (gapCount == GAP_W'(CYCLE_OSC)));

endmodule

// File: tb/dual_slope_sequencer_bench.sv
module dual_slope_sequencer_bench;

  localparam int PRESCALE = 4;
  localparam int INT_C    = 100;
  localparam int DE_MAX   = 200;
  localparam int CYC_C    = 400;
  localparam int ZI_MIN   = 11;
  localparam int ZI_MAX   = 140;
  localparam int ZI_HEAVY = 300;
  localparam int INT_OSC  = INT_C * PRESCALE;
  localparam int CYC_OSC  = CYC_C * PRESCALE;
  localparam int AZ_BOOT  = (CYC_C - INT_C - DE_MAX) * PRESCALE;
  localparam int N_CONV   = 50;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmpCross = 1'b0;
  logic polNeg = 1'b0;
  logic swAutoZero, swIntegrate, swDeRefUp, swDeRefDown, swZeroInt;
  logic [3:0] rdUnits, rdTens, rdHundreds;
  logic rdThousand, rdNegative, rdOverrange;

  always #4 clk = ~clk;

  dual_slope_sequencer #(
    .PRESCALE(PRESCALE), .INT_COUNTS(INT_C), .DE_MAX(DE_MAX),
    .CYCLE_COUNTS(CYC_C), .ZI_MIN(ZI_MIN), .ZI_MAX(ZI_MAX),
    .ZI_HEAVY(ZI_HEAVY)
  ) u_dual_slope_sequencer (
    .clk(clk), .rst(rst), .cmpCross(cmpCross), .polNeg(polNeg),
    .swAutoZero(swAutoZero), .swIntegrate(swIntegrate),
    .swDeRefUp(swDeRefUp), .swDeRefDown(swDeRefDown), .swZeroInt(swZeroInt),
    .rdUnits(rdUnits), .rdTens(rdTens), .rdHundreds(rdHundreds),
    .rdThousand(rdThousand), .rdNegative(rdNegative), .rdOverrange(rdOverrange)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expDeLen(input int n);
    return (n < DE_MAX) ? PRESCALE * (n + 1) : PRESCALE * DE_MAX;
  endfunction

  function automatic int expZiLen(input int n, input int z);
    int k;
    if (n >= DE_MAX) return ZI_HEAVY;
    k = (z < ZI_MIN) ? ZI_MIN : z;
    return (k > ZI_MAX) ? ZI_MAX : k;
  endfunction

  function automatic int decodePhase();
    if (swAutoZero) return 0;
    if (swIntegrate) return 1;
    if (swDeRefUp || swDeRefDown) return 2;
    if (swZeroInt) return 3;
    return 4;
  endfunction

  int dirN[12] = '{0, 1, 9, 10, 99, 100, 199, 200, 5, 350, 0, 150};
  int dirZ[12] = '{0, 500, 50, 11, 140, 12, 7, 20, 141, 3, 139, 60};

  bit started = 0;
  bit bootAz = 1;
  bit done = 0;
  bit haveLatch = 0;
  bit holdBad = 0;
  bit refBad = 0;
  int prevPh = 0;
  int runLen = 0;
  int convCount = 0;
  int curN = 0;
  int curNeg = 0;
  int zTgt = 0;
  int lastDe = 0;
  int lastZi = 0;
  int hU = 0, hT = 0, hH = 0, hK = 0, hNeg = 0, hOvr = 0;

  always @(negedge clk) begin
    int ph;
    if (!rst && started && !done) begin
      ph = decodePhase();
      if (ph != prevPh) begin
        case (prevPh)
          0: begin
            if (bootAz) chk("R10 first auto-zero length", runLen, AZ_BOOT);
            else chk("R8 auto-zero length keeps cycle fixed", runLen,
                     CYC_OSC - INT_OSC - lastDe - lastZi);
            chk("R1 auto-zero followed by integrate", ph, 1);
            if (!bootAz) begin
              chk("R9 reading held between transfers", int'(holdBad), 0);
              chk("R5 de-integrate reference select", int'(refBad), 0);
            end
            bootAz = 0;
            holdBad = 0;
            refBad = 0;
            if (convCount >= N_CONV) done = 1;
            if (convCount < 12) begin
              curN = dirN[convCount];
              zTgt = dirZ[convCount];
            end else begin
              curN = $urandom % 260;
              zTgt = $urandom % 200;
            end
            curNeg = (convCount < 12) ? (convCount % 2) : int'($urandom % 2);
            convCount++;
          end
          1: begin
            chk("R2 signal integrate length (R11 inputs ignored)", runLen, INT_OSC);
            chk("R1 integrate followed by de-integrate", ph, 2);
          end
          2: begin
            lastDe = expDeLen(curN);
            lastZi = expZiLen(curN, zTgt);
            if (curN < DE_MAX) begin
              chk("R3 de-integrate length", runLen, lastDe);
              hU = curN % 10; hT = (curN / 10) % 10; hH = (curN / 100) % 10;
              hK = (curN / 1000) % 2; hOvr = 0;
            end else begin
              chk("R4 overrange de-integrate length", runLen, lastDe);
              hU = 0; hT = 0; hH = 0; hK = 0; hOvr = 1;
            end
            hNeg = curNeg;
            haveLatch = 1;
            chk("R1 de-integrate followed by zero-integrate", ph, 3);
            chk("R9 units digit", int'(rdUnits), hU);
            chk("R9 tens digit", int'(rdTens), hT);
            chk("R9 hundreds digit", int'(rdHundreds), hH);
            chk("R9 thousands digit", int'(rdThousand), hK);
            chk("R4 overrange flag", int'(rdOverrange), hOvr);
            chk("R5 latched sign", int'(rdNegative), hNeg);
          end
          3: begin
            if (curN >= DE_MAX) chk("R7 extended zero-integrate length", runLen, lastZi);
            else chk("R6 zero-integrate length", runLen, lastZi);
            chk("R1 zero-integrate followed by auto-zero", ph, 0);
          end
          default: chk("R1 valid phase encoding", prevPh, 0);
        endcase
        prevPh = ph;
        runLen = 1;
      end else begin
        runLen++;
      end

      if (haveLatch) begin
        if (int'(rdUnits) != hU || int'(rdTens) != hT || int'(rdHundreds) != hH ||
            int'(rdThousand) != hK || int'(rdNegative) != hNeg ||
            int'(rdOverrange) != hOvr) holdBad = 1;
      end

      case (ph)
        0: begin
          cmpCross = 1'($urandom % 2);
          polNeg   = 1'($urandom % 2);
        end
        1: begin
          cmpCross = 1'($urandom % 2);
          polNeg   = 1'(curNeg);
        end
        2: begin
          if (int'(swDeRefUp) != curNeg || int'(swDeRefDown) != 1 - curNeg) refBad = 1;
          polNeg   = 1'($urandom % 2);
          cmpCross = (curN < DE_MAX) && (runLen >= PRESCALE * curN + 1);
        end
        default: begin
          polNeg   = 1'($urandom % 2);
          cmpCross = (runLen >= zTgt);
        end
      endcase
    end
  end

  initial begin
    int cyc;
    void'($urandom(32'd20240517));
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 reset auto-zero enable", int'(swAutoZero), 1);
    chk("R10 reset other enables", int'(swIntegrate | swDeRefUp | swDeRefDown | swZeroInt), 0);
    chk("R10 reset reading", int'({rdThousand, rdHundreds, rdTens, rdUnits}), 0);
    chk("R10 reset flags", int'({rdNegative, rdOverrange}), 0);
    started = 1;
    prevPh = 0;
    runLen = 1;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) chk("R1 watchdog expired before all conversions", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule